// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept. The receive path hands it the six destination-address bytes one per strobe, first byte first. The block then gives one accept or reject verdict for the frame. The verdict depends on three mode inputs (accept everything, accept broadcast, accept multicast), a stored six-byte station address and a 64-bit multicast hash mask. Software loads the station address and the mask through a byte-wide write port.

Frames go through four classes in a fixed priority. Accept-all mode overrides everything else. An all-ones destination is broadcast. A destination whose first byte has bit 0 set is multicast. Every other destination is unicast. For multicast, a bit-serial CRC-32 is run over the 48 address bits, one bit per clock. Six bits of the CRC pick one bit of the mask. The same hashing interval is used for every class, so each verdict arrives a fixed time after the last address byte.

Top module: `rx_addr_filter`

## Requirements
- R1: When `accept_all` is high at the final hashing cycle, the frame is accepted whatever its destination.
- R2: A destination of six 0xFF bytes is broadcast. When `accept_all` is low it is accepted exactly when `accept_bcast` is high. It never takes the multicast path.
- R3: A non-broadcast destination whose first received byte has bit 0 set is multicast. It is rejected while `accept_mcast` is low.
- R4: A multicast frame with `accept_mcast` high is accepted exactly when mask bit `idx` is set. Mask bit `k` is bit `k%8` of the mask byte at register address `8 + k/8`. To get `idx`, a 32-bit CRC starts at 0xFFFFFFFF and takes in the address bits first byte first, least significant bit first. For each bit, c = CRC[31] XOR bit, and the CRC shifts left. When c is 1, the CRC is then XORed with 0x04C11DB6 and ORed with 1. `idx` is CRC[31:26] after the 48th bit.
- R5: A unicast frame with `accept_all` low is accepted exactly when received byte k equals the station byte written at register address k, for k = 0..5.
- R6: Reset clears the station address and the mask to zero and drives `busy`, `result_done` and `result_accept` low.
- R7: `busy` rises on the clock after the sixth byte is taken and stays high for exactly 48 cycles. `result_done` is a single-cycle pulse in the first cycle after `busy` falls, and `result_accept` holds the verdict at that point.
- R8: An address byte is taken only when `addr_valid` is high while `busy` is low. A new frame starts only on a byte flagged by `addr_first`. Bytes offered while `busy` is high are ignored, and so are unflagged bytes offered when no frame is open.
- R9: Register writes to addresses 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Destination byte strobe |
| addr_first | input | 1 | Marks the first destination byte of a frame |
| addr_byte | input | 8 | Destination address byte |
| accept_all | input | 1 | Accept every frame |
| accept_bcast | input | 1 | Accept broadcast frames |
| accept_mcast | input | 1 | Allow multicast frames through the hash mask |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-5 station bytes, 8-15 mask bytes |
| reg_wdata | input | 8 | Register write data |
| busy | output | 1 | Hashing in progress; new bytes are ignored |
| result_done | output | 1 | One-cycle verdict strobe |
| result_accept | output | 1 | Verdict, 1 = accept |

## Verification
The bench sends broadcast frames with only multicast acceptance enabled, and again after the mask has been filled with ones. A filter that tested the group bit before the all-ones pattern would accept them. Unicast frames that differ from the station only in the last byte, or only in the first, catch a comparison that drops a byte or stops early. For multicast, the bench sets exactly the one mask bit given by its own CRC model, so a wrong bit order, preset or index slice shows up as a rejection. Strobes are also offered while hashing and while no frame is open; a filter that took them would give a spurious or shifted verdict.

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          MASK_BYTES = 8,
  parameter int          REG_AW     = 4,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              addr_first,
  input  logic [7:0]        addr_byte,
  input  logic              accept_all,
  input  logic              accept_bcast,
  input  logic              accept_mcast,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              busy,
  output logic              result_done,
  output logic              result_accept
);
  localparam int ABITS     = ADDR_BYTES * 8;
  localparam int MBITS     = MASK_BYTES * 8;
  localparam int IW        = $clog2(MBITS);
  localparam int BCW       = $clog2(ADDR_BYTES + 1);
  localparam int HCW       = $clog2(ABITS);
  localparam int MASK_BASE = 2 ** (REG_AW - 1);

  logic [7:0]       station [ADDR_BYTES];
  logic [MBITS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ADDR_BYTES; i++) station[i] <= '0;
      mask_q <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        if (reg_addr == REG_AW'(i)) station[i] <= reg_wdata;
      for (int j = 0; j < MASK_BYTES; j++)
        if (reg_addr == REG_AW'(MASK_BASE + j)) mask_q[8*j +: 8] <= reg_wdata;
    end
  end

  logic [BCW-1:0]   byte_cnt;
  logic [ABITS-1:0] sh;
  logic             is_mc, all_ones, sta_hit;
  logic             hashing;
  logic [HCW-1:0]   bit_cnt;
  logic [31:0]      crc;

  wire            take_first = addr_valid && addr_first && !hashing;
  wire            take_more  = addr_valid && !addr_first && !hashing && (byte_cnt != '0);
  wire            take       = take_first || take_more;
  wire [BCW-1:0]  pos        = take_first ? '0 : byte_cnt;
  wire            last_byte  = take && (pos == BCW'(ADDR_BYTES - 1));
  wire            byte_hit   = (addr_byte == station[pos]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      sh       <= '0;
      is_mc    <= 1'b0;
      all_ones <= 1'b0;
      sta_hit  <= 1'b0;
    end else if (take) begin
      sh       <= {addr_byte, sh[ABITS-1:8]};
      byte_cnt <= last_byte ? '0 : pos + 1'b1;
      if (take_first) begin
        is_mc    <= addr_byte[0];
        all_ones <= &addr_byte;
        sta_hit  <= byte_hit;
      end else begin
        all_ones <= all_ones && (&addr_byte);
        sta_hit  <= sta_hit && byte_hit;
      end
    end else if (hashing) begin
      sh <= {1'b0, sh[ABITS-1:1]};
    end
  end

  wire           carry     = crc[31] ^ sh[0];
  wire [31:0]    crc_sh    = {crc[30:0], 1'b0};
  wire [31:0]    crc_nx    = carry ? ((crc_sh ^ CRC_POLY) | 32'd1) : crc_sh;
  wire [IW-1:0]  idx       = crc_nx[31 -: IW];
  wire           final_bit = hashing && (bit_cnt == HCW'(ABITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hashing <= 1'b0;
      bit_cnt <= '0;
      crc     <= '1;
    end else if (last_byte) begin
      hashing <= 1'b1;
      bit_cnt <= '0;
      crc     <= '1;
    end else if (hashing) begin
      crc     <= crc_nx;
      bit_cnt <= bit_cnt + 1'b1;
      if (final_bit) hashing <= 1'b0;
    end
  end

  logic verdict;
  always_comb begin
    if (accept_all)    verdict = 1'b1;
    else if (all_ones) verdict = accept_bcast;
    else if (is_mc)    verdict = accept_mcast && mask_q[idx];
    else               verdict = sta_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_done   <= 1'b0;
      result_accept <= 1'b0;
    end else begin
      result_done <= final_bit;
      if (final_bit) result_accept <= verdict;
    end
  end

  assign busy = hashing;
endmodule

// File: rtl/rx_addr_filter_chk.sv
`timescale 1ns/1ps
module rx_addr_filter_chk #(
  parameter int HASH_LEN = 48
) (
  input logic clk,
  input logic rst_n,
  input logic addr_valid,
  input logic accept_all,
  input logic busy,
  input logic result_done,
  input logic result_accept
);
  int run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_done |=> !result_done); // R7
  AST_DONE_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> result_done); // R7
  AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    result_done |-> $past(busy)); // R7
  AST_HASH_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == HASH_LEN); // R7
  AST_START_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(addr_valid)); // R8
  AST_ALL_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (result_done && $past(accept_all)) |-> result_accept); // R1
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.HASH_LEN(ADDR_BYTES * 8)) u_chk (.*);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic clk = 0, rst_n = 0;
  logic addr_valid = 0, addr_first = 0;
  logic [7:0] addr_byte = 0;
  logic accept_all = 0, accept_bcast = 0, accept_mcast = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic busy, result_done, result_accept;

  rx_addr_filter u0 (.*);

  always #5 clk = ~clk;

  typedef struct { bit acc; int edge_no; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0]  sta_m [6];
  logic [63:0] mask_m = '0;

  always @(posedge clk) cyc++;

  function automatic int hash_idx(logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      bit cy;
      cy = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (cy) c = (c ^ 32'h04C11DB6) | 32'd1;
    end
    return int'(c[31:26]);
  endfunction

  function automatic bit model(logic [47:0] a, logic [2:0] m);
    if (m[2]) return 1;
    if (a == '1) return m[1];
    if (a[0]) return m[0] && mask_m[hash_idx(a)];
    return a == {sta_m[5], sta_m[4], sta_m[3], sta_m[2], sta_m[1], sta_m[0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a < 6) sta_m[a] = d;
    else if (a >= 8) mask_m[8*(a-8) +: 8] = d;
  endtask

  // m = {all, bcast, mcast}
  task automatic send(logic [47:0] a, logic [2:0] m, string tag, int gap = 0);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    {accept_all, accept_bcast, accept_mcast} = m;
    for (int i = 0; i < 6; i++) begin
      addr_valid = 1; addr_first = (i == 0); addr_byte = a[8*i +: 8];
      if (i == 5) begin
        e.acc = model(a, m); e.edge_no = cyc + 1 + 48; e.tag = tag;
        q.push_back(e);
      end
      @(negedge clk);
      addr_valid = 0; addr_first = 0;
      if (i < 5) repeat (gap) @(negedge clk);
    end
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && result_done) begin
      if (q.size() == 0) check(0, "R8 unexpected verdict", 1, 0);
      else begin
        e = q.pop_front();
        check(result_accept == e.acc, e.tag, result_accept, e.acc);
        check(cyc == e.edge_no, {"R7 latency ", e.tag}, cyc, e.edge_no);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] sta, m1, m2;
    int i1;
    for (int k = 0; k < 6; k++) sta_m[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R6 busy after reset", busy, 0);
    check(result_done == 0, "R6 done after reset", result_done, 0);
    check(result_accept == 0, "R6 accept after reset", result_accept, 0);

    send(48'h0, 3'b000, "R6 zero station matches zero unicast");
    send(48'h0000005E0001, 3'b001, "R6 cleared mask rejects multicast");

    sta = 48'h554433221102;
    for (int k = 0; k < 6; k++) wr(k, sta[8*k +: 8]);
    send(sta, 3'b000, "R5 exact station match");
    send(sta ^ 48'h010000000000, 3'b000, "R5 last byte differs");
    send(sta ^ 48'h000000000004, 3'b000, "R5 first byte differs", 2);

    send('1, 3'b000, "R2 broadcast disabled");
    send('1, 3'b010, "R2 broadcast enabled", 1);
    send('1, 3'b001, "R2 broadcast with only multicast on");

    m1 = 48'h0100005E0001;
    m2 = 48'h3322110000CD;
    send(m1, 3'b000, "R3 multicast disabled, empty mask");
    i1 = hash_idx(m1);
    wr(8 + i1 / 8, 8'(1 << (i1 % 8)));
    send(m1, 3'b001, "R4 multicast hash bit set");
    send(m1, 3'b010, "R3 multicast disabled, bit set");
    send(m2, 3'b001, "R4 other multicast, single mask bit");
    for (int k = 8; k < 16; k++) wr(k, 8'hFF);
    send(m2, 3'b001, "R4 other multicast, full mask");
    send('1, 3'b001, "R2 broadcast with full mask, bcast off");

    send(48'hAABBCCDDEE10, 3'b100, "R1 foreign unicast accepted");
    send('1, 3'b100, "R1 broadcast accepted");
    send(m2, 3'b100, "R1 multicast accepted");

    wr(6, 8'h77);
    wr(7, 8'h99);
    send(sta, 3'b000, "R9 unmapped writes leave station intact");

    @(negedge clk);
    addr_valid = 1; addr_first = 0; addr_byte = 8'hFF;
    repeat (3) @(negedge clk);
    addr_valid = 0;
    send(sta, 3'b000, "R8 unflagged idle bytes ignored");

    send(sta ^ 48'h000000000008, 3'b000, "R8 frame before busy noise");
    @(negedge clk);
    while (!busy) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      addr_valid = 1; addr_first = (k == 0); addr_byte = 8'hFF;
      @(negedge clk);
    end
    addr_valid = 0; addr_first = 0;
    send(sta, 3'b000, "R8 frame after busy noise");

    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule